// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block moves a processor core into an exception handler and back out of it. On entry it turns the core's program counter, status register, supervisor stack pointer and exception number into a two-longword frame. It pushes the return address and then a packed format word onto the supervisor stack. It raises the status register to supervisor state and fetches the handler address from the vector table. On a return request it reads the frame back, restores the program counter and status register, and puts the stack pointer back to the byte alignment it had before the frame was built.

All memory traffic goes through one longword request/response port. The block holds a request with a steady address until the memory acknowledges it. Software exceptions, hardware interrupts and returns share the same port. A hardware interrupt is taken only when its pending level beats the mask in the status register. The caller supplies the stack pointer that is already switched to the supervisor stack. The results appear on registered outputs, together with a one-cycle completion pulse.

Top module: `exc_frame_seq`

## Requirements
- R1: The pushed format word has bits 31:30 = 2'b01, bits 29:28 = the two low bits of the incoming stack pointer, bits 27:26 = 0, bits 25:16 = exception number times 4, and bits 15:0 = the incoming status register.
- R2: On entry the stack pointer is first cleared to a multiple of 4 (call it A). The return address is written at A-4 and the format word at A-8. The reported new stack pointer is A-8. Every write address has its two low bits at zero.
- R3: On entry the memory sequence is exactly three accesses: the write of the return address, then the write of the format word, then the read of the handler address.
- R4: On entry the new status register has bit 13 (supervisor) set and all other bits unchanged for a software exception. For a hardware interrupt, bits 10:8 (mask) also take the pending level and bit 12 (master) is cleared.
- R5: For a software exception whose number is in 32..47 (the sixteen trap numbers), the saved return address is the current PC plus 2. For any other number, and for every hardware interrupt, it is the current PC.
- R6: The handler address is the longword read from the vector base plus exception number times 4, and it is reported as the new PC.
- R7: A return (req_op = 2) reads the format word at SP, then the PC at SP+4. It reports new PC = second longword, new status register = bits 15:0 of the format word, and new stack pointer = (SP OR format bits 29:28) + 8.
- R8: A hardware interrupt request (req_op = 1) is accepted only when irq_level is strictly greater than cur_sr bits 10:8. A refused request starts no memory access, does not raise busy and gives no completion pulse.
- R9: busy is high from the cycle after an accepted request until completion. Any request presented while busy is high is ignored.
- R10: done is a one-cycle pulse in the cycle in which the new PC, SR and SP outputs first hold the results. mem_req, mem_we, mem_addr and mem_wdata stay unchanged until mem_ack.
- R11: After reset, busy, done and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 2 | 0 software exception, 1 hardware interrupt, 2 return |
| exc_num | input | NUM_W | Exception or interrupt vector number |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status register including condition codes |
| sup_sp | input | 32 | Supervisor stack pointer |
| vbr | input | 32 | Vector table base address |
| irq_level | input | 3 | Pending hardware interrupt level |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Longword byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| new_pc | output | 32 | Handler or restored program counter |
| new_sr | output | 16 | Updated or restored status register |
| new_sp | output | 32 | Stack pointer after push or pop |

## Verification
Software exceptions are tried with numbers at both edges of the trap window and just outside it, so that an off-by-one in the return-address adjustment shows up. Stack pointers with each of the four low-bit patterns are each followed by a return from the frame just built; the round trip tells a lost or misplaced alignment field from a correct one. Hardware interrupts are tried with the level above, equal to and below the mask, which separates a strict from a non-strict comparison, and once with a number inside the trap window to show that interrupts never adjust the PC. A second request presented while busy, and memories with different acknowledge latencies, show that stale requests are dropped and that held requests do not move.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

  typedef enum logic [1:0] {
    OP_EXC = 2'd0,
    OP_IRQ = 2'd1,
    OP_RET = 2'd2,
    OP_NONE = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_FMT,
    ST_FETCH,
    ST_POP_FMT,
    ST_POP_PC
  } seq_st_e;

  localparam int SR_S_BIT   = 13;
  localparam int SR_M_BIT   = 12;
  localparam int SR_IPL_LSB = 8;
  localparam int IPL_W      = 3;
  localparam int WORD_W     = 32;
  localparam int SR_W       = 16;
  localparam logic [1:0] FMT_CODE = 2'b01;

endpackage

// File: rtl/exc_frame_build.sv
module exc_frame_build
  import exc_frame_pkg::*;
#(
  parameter int NUM_W      = 8,
  parameter int TRAP_BASE  = 32,
  parameter int TRAP_COUNT = 16
) (
  input  req_op_e               op,
  input  logic [NUM_W-1:0]      exc_num,
  input  logic [WORD_W-1:0]     cur_pc,
  input  logic [SR_W-1:0]       cur_sr,
  input  logic [WORD_W-1:0]     sup_sp,
  input  logic [WORD_W-1:0]     vbr,
  input  logic [IPL_W-1:0]      irq_level,
  output logic [WORD_W-1:0]     fmt_word,
  output logic [WORD_W-1:0]     ret_pc,
  output logic [WORD_W-1:0]     sp_base,
  output logic [WORD_W-1:0]     vec_addr,
  output logic [SR_W-1:0]       entry_sr,
  output logic                  irq_ok
);
  localparam int OFF_W = NUM_W + 2;
  localparam logic [WORD_W-1:0] TRAP_LO = WORD_W'(TRAP_BASE);
  localparam logic [WORD_W-1:0] TRAP_HI = WORD_W'(TRAP_BASE + TRAP_COUNT);

  logic [OFF_W-1:0]  vec_off;
  logic [WORD_W-1:0] off_ext;
  logic [WORD_W-1:0] num_ext;
  logic              in_trap;

  assign vec_off = {exc_num, 2'b00};
  assign off_ext = {{(WORD_W-OFF_W){1'b0}}, vec_off};
  assign num_ext = {{(WORD_W-NUM_W){1'b0}}, exc_num};
  assign in_trap = (num_ext >= TRAP_LO) && (num_ext < TRAP_HI);

  assign fmt_word = {FMT_CODE, sup_sp[1:0], 28'd0}
                  | (off_ext << 16)
                  | {16'd0, cur_sr};
  assign ret_pc   = (op == OP_EXC && in_trap) ? cur_pc + 32'd2 : cur_pc;
  assign sp_base  = {sup_sp[WORD_W-1:2], 2'b00};
  assign vec_addr = vbr + off_ext;
  assign irq_ok   = irq_level > cur_sr[SR_IPL_LSB +: IPL_W];

  always_comb begin
    entry_sr = cur_sr;
    entry_sr[SR_S_BIT] = 1'b1;
    if (op == OP_IRQ) begin
      entry_sr[SR_M_BIT] = 1'b0;
      entry_sr[SR_IPL_LSB +: IPL_W] = irq_level;
    end
  end

endmodule

// File: rtl/exc_frame_unpack.sv
module exc_frame_unpack
  import exc_frame_pkg::*;
(
  input  logic [WORD_W-1:0] frame_sp,
  input  logic [1:0]        align_bits,
  output logic [WORD_W-1:0] rest_sp
);
  assign rest_sp = (frame_sp | {{(WORD_W-2){1'b0}}, align_bits}) + 32'd8;
endmodule

// File: rtl/exc_frame_fsm.sv
module exc_frame_fsm
  import exc_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  req_op_e           op,
  input  logic              irq_ok,
  input  logic [WORD_W-1:0] fmt_word,
  input  logic [WORD_W-1:0] ret_pc,
  input  logic [WORD_W-1:0] sp_base,
  input  logic [WORD_W-1:0] vec_addr,
  input  logic [SR_W-1:0]   entry_sr,
  input  logic [WORD_W-1:0] sup_sp,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] new_pc,
  output logic [SR_W-1:0]   new_sr,
  output logic [WORD_W-1:0] new_sp
);
  seq_st_e           state;
  logic [WORD_W-1:0] lat_fmt;
  logic [WORD_W-1:0] lat_sp;
  logic [WORD_W-1:0] lat_vec;
  logic [SR_W-1:0]   lat_sr;
  logic [1:0]        lat_align;
  logic [WORD_W-1:0] rest_sp;
  logic              take_entry;
  logic              take_ret;
  logic              step;

  assign take_entry = req_valid && !busy &&
                      (op == OP_EXC || (op == OP_IRQ && irq_ok));
  assign take_ret   = req_valid && !busy && op == OP_RET;
  assign step       = mem_req && mem_ack;

  exc_frame_unpack u_unpack (
    .frame_sp   (lat_sp),
    .align_bits (lat_align),
    .rest_sp    (rest_sp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      lat_fmt   <= '0;
      lat_sp    <= '0;
      lat_vec   <= '0;
      lat_sr    <= '0;
      lat_align <= '0;
      new_pc    <= '0;
      new_sr    <= '0;
      new_sp    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take_entry) begin
            lat_fmt   <= fmt_word;
            lat_sp    <= sp_base;
            lat_vec   <= vec_addr;
            lat_sr    <= entry_sr;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= sp_base - 32'd4;
            mem_wdata <= ret_pc;
            busy      <= 1'b1;
            state     <= ST_PUSH_PC;
          end else if (take_ret) begin
            lat_sp    <= sup_sp;
            mem_req   <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= sup_sp;
            busy      <= 1'b1;
            state     <= ST_POP_FMT;
          end
        end
        ST_PUSH_PC: if (step) begin
          mem_addr  <= lat_sp - 32'd8;
          mem_wdata <= lat_fmt;
          state     <= ST_PUSH_FMT;
        end
        ST_PUSH_FMT: if (step) begin
          mem_we    <= 1'b0;
          mem_addr  <= lat_vec;
          state     <= ST_FETCH;
        end
        ST_FETCH: if (step) begin
          mem_req <= 1'b0;
          new_pc  <= mem_rdata;
          new_sr  <= lat_sr;
          new_sp  <= lat_sp - 32'd8;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_POP_FMT: if (step) begin
          lat_align <= mem_rdata[29:28];
          lat_sr    <= mem_rdata[SR_W-1:0];
          mem_addr  <= lat_sp + 32'd4;
          state     <= ST_POP_PC;
        end
        ST_POP_PC: if (step) begin
          mem_req <= 1'b0;
          new_pc  <= mem_rdata;
          new_sr  <= lat_sr;
          new_sp  <= rest_sp;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: a pending request does not move until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R2: stack writes are longword aligned
  p_push_align_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_addr[1:0] == 2'b00);

  // R1: the second push carries the fixed format code
  p_fmt_code_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_PUSH_FMT && mem_req |-> mem_wdata[31:30] == 2'b01);

  // R9: completion coincides with busy falling
  p_done_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  // R4: after an entry sequence the supervisor bit is set
  p_entry_super_r4: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH && mem_ack |=> new_sr[SR_S_BIT]);

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int NUM_W      = 8,
  parameter int TRAP_BASE  = 32,
  parameter int TRAP_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [NUM_W-1:0]  exc_num,
  input  logic [31:0]       cur_pc,
  input  logic [15:0]       cur_sr,
  input  logic [31:0]       sup_sp,
  input  logic [31:0]       vbr,
  input  logic [2:0]        irq_level,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       new_pc,
  output logic [15:0]       new_sr,
  output logic [31:0]       new_sp
);
  req_op_e           op;
  logic [WORD_W-1:0] fmt_word;
  logic [WORD_W-1:0] ret_pc;
  logic [WORD_W-1:0] sp_base;
  logic [WORD_W-1:0] vec_addr;
  logic [SR_W-1:0]   entry_sr;
  logic              irq_ok;

  assign op = req_op_e'(req_op);

  exc_frame_build #(
    .NUM_W      (NUM_W),
    .TRAP_BASE  (TRAP_BASE),
    .TRAP_COUNT (TRAP_COUNT)
  ) u_build (
    .op        (op),
    .exc_num   (exc_num),
    .cur_pc    (cur_pc),
    .cur_sr    (cur_sr),
    .sup_sp    (sup_sp),
    .vbr       (vbr),
    .irq_level (irq_level),
    .fmt_word  (fmt_word),
    .ret_pc    (ret_pc),
    .sp_base   (sp_base),
    .vec_addr  (vec_addr),
    .entry_sr  (entry_sr),
    .irq_ok    (irq_ok)
  );

  exc_frame_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .op        (op),
    .irq_ok    (irq_ok),
    .fmt_word  (fmt_word),
    .ret_pc    (ret_pc),
    .sp_base   (sp_base),
    .vec_addr  (vec_addr),
    .entry_sr  (entry_sr),
    .sup_sp    (sup_sp),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .new_pc    (new_pc),
    .new_sr    (new_sr),
    .new_sp    (new_sp)
  );

  // R8: an interrupt at or below the mask level never starts a sequence
  p_irq_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 2'd1 && irq_level <= cur_sr[10:8] && !busy |=> !busy);

  // R11: quiet outputs right after reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> !busy && !done && !mem_req);

endmodule

// File: tb/exc_frame_seq_tb_top.sv
`timescale 1ns/1ps
module exc_frame_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  exc_num = 8'd0;
  logic [31:0] cur_pc = 32'd0;
  logic [15:0] cur_sr = 16'd0;
  logic [31:0] sup_sp = 32'd0;
  logic [31:0] vbr = 32'd0;
  logic [2:0]  irq_level = 3'd0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done;
  logic [31:0] new_pc, new_sp;
  logic [15:0] new_sr;

  always #2.5 clk = ~clk;

  exc_frame_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .exc_num(exc_num), .cur_pc(cur_pc), .cur_sr(cur_sr), .sup_sp(sup_sp),
    .vbr(vbr), .irq_level(irq_level), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .new_pc(new_pc),
    .new_sr(new_sr), .new_sp(new_sp)
  );

  typedef struct { logic [31:0] a; bit w; logic [31:0] d; } acc_t;
  acc_t        q[$];
  logic [31:0] mem_q [logic [31:0]];
  int          checks = 0, errors = 0, cycles = 0, wait_n = 0, wcnt = 0;
  bit          pend_done = 0, armed = 0;
  logic [31:0] e_pc, e_sp;
  logic [15:0] e_sr;
  string       cur_tag = "";

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem_q.exists(a)) return mem_q[a];
    return (a ^ 32'h5A00_0000) + 32'h11;
  endfunction

  // memory model with programmable acknowledge latency
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= 32'd0;
      wcnt <= 0;
    end else begin
      if (mem_req && mem_ack && mem_we) mem_q[mem_addr] = mem_wdata;
      if (mem_req && !mem_ack) begin
        if (wcnt >= wait_n) begin
          mem_ack <= 1'b1;
          mem_rdata <= rd(mem_addr);
          wcnt <= 0;
        end else begin
          wcnt <= wcnt + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%h expected=%h", tag, cur_tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick();
    acc_t x;
    @(negedge clk);
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
    if (armed) begin
      chk(busy === (q.size() > 0), "R9 busy level", {31'd0, busy}, {31'd0, q.size() > 0});
      chk(done === pend_done, "R10 done pulse", {31'd0, done}, {31'd0, pend_done});
      if (pend_done && done) begin
        chk(new_pc === e_pc, "R6/R7 new_pc", new_pc, e_pc);
        chk(new_sr === e_sr, "R4/R7 new_sr", {16'd0, new_sr}, {16'd0, e_sr});
        chk(new_sp === e_sp, "R2/R7 new_sp", new_sp, e_sp);
      end
      pend_done = 0;
      if (mem_req && mem_ack) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected memory access", mem_addr, 32'd0);
        end else begin
          x = q.pop_front();
          chk(mem_addr === x.a, "R3 access address", mem_addr, x.a);
          chk(mem_we === x.w, "R3 access direction", {31'd0, mem_we}, {31'd0, x.w});
          if (x.w) chk(mem_wdata === x.d, "R1/R5 write data", mem_wdata, x.d);
          if (q.size() == 0) pend_done = 1;
        end
      end
    end
    req_valid = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input int num, input logic [31:0] pc,
                       input logic [15:0] sr, input logic [31:0] sp,
                       input logic [31:0] vb, input int lvl, input string tag);
    logic [31:0] ret, spa, fmt, vaddr;
    logic [15:0] esr;
    logic [31:0] f;
    bit idle, take;
    req_op = op; exc_num = num[7:0]; cur_pc = pc; cur_sr = sr;
    sup_sp = sp; vbr = vb; irq_level = lvl[2:0]; req_valid = 1'b1;
    idle = (q.size() == 0) && !pend_done;
    take = idle && (op == 2'd0 || op == 2'd2 || (op == 2'd1 && lvl > int'(sr[10:8])));
    if (!take) return;
    cur_tag = tag;
    if (op == 2'd2) begin
      f = rd(sp);
      q.push_back('{sp, 1'b0, 32'd0});
      q.push_back('{sp + 32'd4, 1'b0, 32'd0});
      e_pc = rd(sp + 32'd4);
      e_sr = f[15:0];
      e_sp = (sp + 32'(f[29:28])) + 32'd8;
    end else begin
      ret = (op == 2'd0 && num >= 32 && num <= 47) ? pc + 32'd2 : pc;
      spa = sp - 32'(sp % 4);
      fmt = 32'h4000_0000 + (32'(sp % 4) << 28) + (32'(num * 4) << 16) + 32'(sr);
      vaddr = vb + 32'(num * 4);
      esr = sr | 16'h2000;
      if (op == 2'd1) esr = (esr & 16'hE8FF) | (16'(lvl) << 8);
      q.push_back('{spa - 32'd4, 1'b1, ret});
      q.push_back('{spa - 32'd8, 1'b1, fmt});
      q.push_back('{vaddr, 1'b0, 32'd0});
      e_pc = rd(vaddr);
      e_sr = esr;
      e_sp = spa - 32'd8;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60; i++) begin
      tick();
      if (q.size() == 0 && !pend_done) break;
    end
    tick();
  endtask

  initial begin
    repeat (3) tick();
    // R11: reset state
    chk(busy === 1'b0, "R11 busy in reset", {31'd0, busy}, 32'd0);
    chk(done === 1'b0, "R11 done in reset", {31'd0, done}, 32'd0);
    chk(mem_req === 1'b0, "R11 mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;
    armed = 1;
    tick();

    issue(2'd0, 5, 32'h1000_0100, 16'h0015, 32'h0000_2000, 32'h0000_0400, 0, "R1 R4 R6 plain exception");
    wait_idle();
    issue(2'd0, 32, 32'h1000_0200, 16'h0004, 32'h0000_2100, 32'h0000_0400, 0, "R5 first trap");
    wait_idle();
    wait_n = 2;
    issue(2'd0, 47, 32'h1000_0300, 16'h2700, 32'h0000_2200, 32'h0000_0400, 0, "R5 last trap");
    wait_idle();
    issue(2'd0, 48, 32'h1000_0400, 16'h0000, 32'h0000_2300, 32'h0000_0800, 0, "R5 above traps");
    wait_idle();
    wait_n = 1;
    issue(2'd0, 31, 32'h1000_0500, 16'h001F, 32'h0000_2400, 32'h0000_0800, 0, "R5 below traps");
    wait_idle();

    // R2 R7: every misalignment followed by a return from that frame
    for (int k = 0; k < 4; k++) begin
      wait_n = k % 3;
      issue(2'd0, 10 + k, 32'h2000_0000 + 32'(k * 16), 16'h0011 + 16'(k), 32'h0000_3000 + 32'(k * 256) + 32'(k),
            32'h0000_0400, 0, "R2 misaligned stack");
      wait_idle();
      issue(2'd2, 0, 32'd0, 16'h2000, 32'h0000_3000 + 32'(k * 256) - 32'd8, 32'd0, 0, "R7 return restores alignment");
      wait_idle();
    end
    issue(2'd2, 0, 32'd0, 16'h2000, 32'h0000_5000, 32'd0, 0, "R7 return from preset memory");
    wait_idle();

    // R4 R8: interrupts
    wait_n = 0;
    issue(2'd1, 64, 32'h3000_0000, 16'h1319, 32'h0000_4000, 32'h0000_0400, 5, "R4 R8 irq above mask");
    wait_idle();
    issue(2'd1, 40, 32'h3000_0100, 16'h2600, 32'h0000_4100, 32'h0000_0400, 7, "R5 irq in trap range");
    wait_idle();
    issue(2'd1, 70, 32'h3000_0200, 16'h0300, 32'h0000_4200, 32'h0000_0400, 3, "R8 irq equal to mask");
    repeat (6) tick();
    issue(2'd1, 71, 32'h3000_0300, 16'h0300, 32'h0000_4300, 32'h0000_0400, 2, "R8 irq below mask");
    repeat (6) tick();
    chk(busy === 1'b0, "R8 refused irq leaves block idle", {31'd0, busy}, 32'd0);

    // R9: request during busy is dropped
    wait_n = 1;
    issue(2'd0, 6, 32'h4000_0000, 16'h0000, 32'h0000_4400, 32'h0000_0400, 0, "R9 first of two");
    tick();
    issue(2'd0, 9, 32'h5555_0000, 16'h00FF, 32'h0000_6000, 32'h0000_0C00, 0, "R9 ignored while busy");
    wait_idle();
    issue(2'd0, 33, 32'h4000_0100, 16'h0001, 32'h0000_4500, 32'h0000_0400, 0, "R10 after ignored request");
    wait_idle();

    finish_run();
  end

endmodule